// File: doc/BRIEF.md
# Byte-Wide Erasable ROM Model with Mode Decode and Identifier Readout

This block is a synthesizable behavioural model of a byte-wide, ultraviolet-erasable read-only memory. It is meant to sit as a test target beside a memory controller or a device programmer. Each clock edge it samples a chip-select, an output-gate that doubles as the programming-voltage pin (the presence of programming voltage is a separate flag), the address bus, and a flag that marks a high voltage on address bit 9. From these it picks one of seven modes: read, output disable, standby, program, program verify, program inhibit or identifier (auto-select) readout.

The storage array has a parameterised depth. On reset it holds all ones, as an erased part does. Programming can only turn ones into zeros, and an erase input returns every location to all ones. The bidirectional data pins are split into a data input, a data output and an output-drive enable. Every output is registered, so a response appears one clock after the edge that sampled the request. Analog access delays and supply current are not modelled.

Top module: `eprom_model`

## Requirements
- R1: After reset every location reads 8'hFF, and while reset holds, dout_en, dout and id_err are all 0.
- R2: With ce_n=0, oe_n=0, vpp_hi=0 and a9_hv=0 sampled at an edge, the cycle after that edge shows dout_en=1 and dout equal to the byte stored at addr.
- R3: With ce_n=0, oe_n=1 and vpp_hi=0, the next cycle shows dout_en=0 and dout=8'h00.
- R4: With ce_n=1, the next cycle shows dout_en=0 and dout=8'h00, whatever oe_n, a9_hv and addr are.
- R5: With ce_n=0 and vpp_hi=1 at an edge, the byte at addr becomes its old value ANDed with din, so no bit returns to 1. The next cycle shows dout_en=0.
- R6: With ce_n=1 and vpp_hi=1 (inhibit), no location changes.
- R7: A read issued after a program operation returns the new byte (program verify).
- R8: With ce_n=0, oe_n=0, vpp_hi=0, a9_hv=1 and every address bit other than bits 0 and 9 at 0, the next cycle drives 8'h01 when addr[0]=0 and 8'h91 when addr[0]=1. Address bit 9 is ignored in this case.
- R9: Both identifier bytes have odd parity, with bit 7 the parity bit computed from the 7-bit identifier parameters.
- R10: An identifier access with any address bit other than 0 and 9 set drives 8'hFF with id_err=1 for that one cycle. id_err is 0 in every other mode.
- R11: erase=1 at an edge sets every location to 8'hFF, and it wins over a program operation at the same edge.
- R12: The release of rst_n is synchronised. The first request is answered only on the third rising edge after rst_n rises, and the outputs stay 0 until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming voltage present on the output-gate pin |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| erase | input | 1 | Restore every location to all ones |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data to program |
| dout | output | 8 | Registered read data, 0 when not driven |
| dout_en | output | 1 | Data pins driven |
| id_err | output | 1 | Identifier access with stray address bits set |

## Verification
The bench builds the block with ADDR_W=10. This is the smallest width that still has an address bit 9, and it gives a 1024-byte array. That width lets the bench reach the top location 10'h3FF, and it lets it show that bit 9 is ignored during identifier readout while bits 1 to 8 are not. The identifier parameters keep their defaults, so the parity of both identifier bytes is checked against the fixed values 8'h01 and 8'h91.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_PROGRAM,
    MD_DISABLE,
    MD_READ,
    MD_IDENT
  } mode_e;

  // Appends an odd-parity bit in bit 7 (R9).
  function automatic logic [BYTE_W-1:0] odd_id(input logic [BYTE_W-2:0] raw);
    return {~(^raw), raw};
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int HV_BIT   = 9
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  output mode_e             mode,
  output logic              id_addr_ok
);

  localparam logic [ADDR_W-1:0] FREE_BITS = ADDR_W'(1) | (ADDR_W'(1) << HV_BIT);
  localparam logic [ADDR_W-1:0] ID_MASK   = ~FREE_BITS;

  always_comb begin
    if (ce_n) begin
      mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;   // R4, R6
    end else if (vpp_hi) begin
      mode = MD_PROGRAM;                         // R5
    end else if (oe_n) begin
      mode = MD_DISABLE;                         // R3
    end else if (a9_hv) begin
      mode = MD_IDENT;                           // R8
    end else begin
      mode = MD_READ;                            // R2, R7
    end
  end

  assign id_addr_ok = ((addr & ID_MASK) == '0);  // R10

endmodule

// File: rtl/eprom_array.sv
module eprom_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  // Erased state is all ones; a write can only clear bits (R1, R5, R11).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[addr] <= cells[addr] & wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/eprom_id_sel.sv
module eprom_id_sel
  import eprom_pkg::*;
#(
  parameter logic [BYTE_W-2:0] MFR_RAW = 7'h01,
  parameter logic [BYTE_W-2:0] DEV_RAW = 7'h11
) (
  input  logic              sel_dev,
  output logic [BYTE_W-1:0] id_byte
);

  localparam logic [BYTE_W-1:0] MFR_BYTE = odd_id(MFR_RAW);
  localparam logic [BYTE_W-1:0] DEV_BYTE = odd_id(DEV_RAW);

  assign id_byte = sel_dev ? DEV_BYTE : MFR_BYTE;

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int                ADDR_W  = 10,
  parameter logic [BYTE_W-2:0] MFR_RAW = 7'h01,
  parameter logic [BYTE_W-2:0] DEV_RAW = 7'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en,
  output logic              id_err
);

  localparam int HV_BIT = 9;

  // Reset: asserted at once, released through two flops (R12).
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  mode_e             mode;
  logic              id_addr_ok;
  logic [BYTE_W-1:0] cell_q;
  logic [BYTE_W-1:0] id_byte;
  logic              wr_en;

  eprom_mode_dec #(
    .ADDR_W (ADDR_W),
    .HV_BIT (HV_BIT)
  ) u_dec (
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .vpp_hi     (vpp_hi),
    .a9_hv      (a9_hv),
    .addr       (addr),
    .mode       (mode),
    .id_addr_ok (id_addr_ok)
  );

  assign wr_en = rst_s && (mode == MD_PROGRAM);

  eprom_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_s),
    .erase (erase),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (din),
    .rdata (cell_q)
  );

  eprom_id_sel #(
    .MFR_RAW (MFR_RAW),
    .DEV_RAW (DEV_RAW)
  ) u_id (
    .sel_dev (addr[0]),
    .id_byte (id_byte)
  );

  // Output next-state.
  logic [BYTE_W-1:0] dout_d;
  logic              en_d;
  logic              err_d;

  always_comb begin
    dout_d = '0;
    en_d   = 1'b0;
    err_d  = 1'b0;
    unique case (mode)
      MD_READ: begin
        dout_d = cell_q;
        en_d   = 1'b1;
      end
      MD_IDENT: begin
        en_d = 1'b1;
        if (id_addr_ok) begin
          dout_d = id_byte;
        end else begin
          dout_d = '1;
          err_d  = 1'b1;
        end
      end
      default: begin
        dout_d = '0;
        en_d   = 1'b0;
        err_d  = 1'b0;
      end
    endcase
  end

  // Output registers.
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      dout    <= '0;
      dout_en <= 1'b0;
      id_err  <= 1'b0;
    end else begin
      dout    <= dout_d;
      dout_en <= en_d;
      id_err  <= err_d;
    end
  end

endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk
  import eprom_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rst_s,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic [BYTE_W-1:0] dout,
  input logic              dout_en,
  input logic              id_err
);

  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!dout_en && dout == '0));

  assert_disable_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |=> !dout_en);

  assert_program_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi |=> !dout_en);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_s && !ce_n && !oe_n && !vpp_hi && !a9_hv) |=> (dout_en && !id_err));

  assert_id_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_s && !ce_n && !oe_n && !vpp_hi && a9_hv) |=> (id_err || (^dout)));

  assert_err_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    id_err |-> (dout_en && dout == '1));

  assert_undriven_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0 && !id_err));

endmodule

bind eprom_model eprom_model_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_s   (rst_s),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .vpp_hi  (vpp_hi),
  .a9_hv   (a9_hv),
  .dout    (dout),
  .dout_en (dout_en),
  .id_err  (id_err)
);

// File: tb/test_eprom_model.sv
module test_eprom_model;

  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, vpp_hi, a9_hv, erase;
  logic [AW-1:0] addr;
  logic [7:0]    din;
  logic [7:0]    dout;
  logic          dout_en, id_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  eprom_model #(.ADDR_W(AW)) i_eprom_model (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .erase(erase), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .id_err(id_err)
  );

  typedef struct packed {
    logic          ce_n, oe_n, vpp, a9, ers;
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic          en;
    logic [7:0]    q;
    logic          err;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 10'h005, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd1 },  // R1 erased
    '{1'b0,1'b1,1'b1,1'b0,1'b0, 10'h005, 8'hA5, 1'b0, 8'h00, 1'b0, 4'd5 },  // R5 program
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 10'h005, 8'h00, 1'b1, 8'hA5, 1'b0, 4'd7 },  // R7 verify
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 10'h005, 8'h5A, 1'b0, 8'h00, 1'b0, 4'd5 },  // R5 oe low
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 10'h005, 8'h00, 1'b1, 8'h00, 1'b0, 4'd5 },  // R5 AND
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 10'h006, 8'h3C, 1'b0, 8'h00, 1'b0, 4'd6 },  // R6 inhibit
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 10'h006, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd6 },  // R6 unchanged
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 10'h005, 8'h00, 1'b0, 8'h00, 1'b0, 4'd3 },  // R3
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 10'h001, 8'h00, 1'b0, 8'h00, 1'b0, 4'd4 },  // R4
    '{0,0,0,1,0, 10'h000, 8'h00, 1'b1, 8'h01, 1'b0, 4'd8 },                 // R8 mfr
    '{0,0,0,1,0, 10'h001, 8'h00, 1'b1, 8'h91, 1'b0, 4'd8 },                 // R8 dev
    '{0,0,0,1,0, 10'h201, 8'h00, 1'b1, 8'h91, 1'b0, 4'd8 },                 // R8 bit 9 free
    '{0,0,0,1,0, 10'h004, 8'h00, 1'b1, 8'hFF, 1'b1, 4'd10},                 // R10
    '{0,0,0,1,0, 10'h101, 8'h00, 1'b1, 8'hFF, 1'b1, 4'd10},                 // R10
    '{0,0,0,0,0, 10'h004, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd10},                 // R10 no err on read
    '{0,1,1,0,0, 10'h3FF, 8'h0F, 1'b0, 8'h00, 1'b0, 4'd5 },                 // R5 top
    '{0,0,0,0,0, 10'h3FF, 8'h00, 1'b1, 8'h0F, 1'b0, 4'd2 },                 // R2
    '{0,1,1,0,1, 10'h007, 8'h00, 1'b0, 8'h00, 1'b0, 4'd11},                 // R11 erase+prog
    '{0,0,0,0,0, 10'h005, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd11},                 // R11
    '{0,0,0,0,0, 10'h007, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd11},                 // R11 erase wins
    '{0,0,0,0,0, 10'h3FF, 8'h00, 1'b1, 8'hFF, 1'b0, 4'd11}                  // R11
  };

  task automatic chk(input bit ok, input int rq, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
    end
  endtask

  // One access: drive at a falling edge, observe at the next falling edge.
  task automatic access(input logic c, o, v, h, e, input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = c; oe_n = o; vpp_hi = v; a9_hv = h; erase = e; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; a9_hv = 1'b0; erase = 1'b0;
    addr = 10'h005; din = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk(dout_en == 1'b0 && dout == 8'h00 && id_err == 1'b0, 1,
        {id_err, dout_en, dout}, 10'h000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12: two edges after release, still quiet
    chk(dout_en == 1'b0, 12, {9'h0, dout_en}, 10'h000);
    @(negedge clk);
    // R12: third edge answers the read
    chk(dout_en == 1'b1 && dout == 8'hFF, 12, {1'b0, dout_en, dout}, 10'h1FF);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].ce_n, VECS[i].oe_n, VECS[i].vpp, VECS[i].a9, VECS[i].ers,
             VECS[i].a, VECS[i].d);
      chk(dout_en == VECS[i].en && dout == VECS[i].q && id_err == VECS[i].err,
          int'(VECS[i].rq), {id_err, dout_en, dout},
          {VECS[i].err, VECS[i].en, VECS[i].q});
      // R9: every valid identifier byte has odd parity
      if (VECS[i].rq == 4'd8)
        chk(^dout == 1'b1, 9, {9'h0, ^dout}, 10'h001);
    end

    // R1: reset mid-run restores the erased state
    access(0, 1, 1, 0, 0, 10'h008, 8'h00);
    access(0, 0, 0, 0, 0, 10'h008, 8'h00);
    chk(dout == 8'h00 && dout_en, 5, {2'b0, dout}, 10'h000);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout == 8'hFF && dout_en, 1, {1'b0, dout_en, dout}, 10'h1FF);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule